// File: doc/BRIEF.md
# Multi-Lane Serial Flash Transaction Sequencer

This block is the master-side engine that runs one complete serial flash transaction while holding a single active-low chip select low. A transaction always begins with one opcode byte. After it come up to four address bytes, a programmable run of dummy clocks, any number of write bytes, and finally any number of read bytes. A 3-bit format code decides how many data lanes (1, 2 or 4) each of these phases uses. The opcode, the address and the write bytes all arrive on one valid/ready byte stream, in that order. Captured read bytes leave on a second valid/ready stream.

The serial clock is paced from outside. A separate clock generator supplies two single-cycle strobes. The capture strobe raises SCK and samples the input lanes. The launch strobe lowers SCK and moves the engine to the next bit group. A strobe that arrives while the engine is waiting for a write byte, or while the read output is still full, is ignored. Two sticky status flags report that all transmit bytes have been sent and that all requested read bytes have been captured. A start request made while a transaction is still running is refused and reported.

Top module: `sflash_seq`

## Requirements
- R1: While reset is held and after it is released, chip select is high, SCK is low, all four lane enables are low, busy is low, tx_ready and rx_valid are low, and both done flags are low.
- R2: The opcode goes out MSB first. It uses 4 lanes for format 7, 2 lanes for format 6, and DQ0 alone for every other format. In multi-lane beats the higher-order bits appear on the higher-numbered lanes.
- R3: Address bytes use one lane for formats 0 to 3, two lanes (DQ[1:0]) for formats 4 and 6, and four lanes (DQ[3:0]) for formats 5 and 7.
- R4: Write and read data use one lane for formats 0 and 1, two lanes for formats 2, 4 and 6, and four lanes for formats 3, 5 and 7. A byte takes 8, 4 or 2 SCK periods. In one-lane receive the input is sampled on DQ1.
- R5: The requested number of dummy SCK periods follows the address. During these periods, and during reads, all lanes are released (enable 0) when the data width is 2 or 4. With one-lane data only DQ0 stays driven, and it is driven low.
- R6: The phases run in the order opcode, address, dummy, write, read. A phase with a count of zero is skipped. Exactly 1 + address count + write count bytes are taken from the write stream.
- R7: Read bytes are assembled MSB first and offered on the read stream. An offered byte and its valid are held until accepted. The receive-done flag rises once the last requested byte is captured. With a read count of zero, no byte is offered and the flag stays low.
- R8: The transmit-done flag is set when the last bit of the last outgoing byte (opcode, address or write data) has been sent. Both done flags are cleared when a new start is accepted.
- R9: A start request made while busy produces a one-cycle refusal pulse on the next cycle. It leaves the running transaction unchanged.
- R10: Chip select goes low when a start is accepted. SCK rises on an accepted capture strobe and falls on the following launch strobe. After the last bit, chip select stays low for one more full SCK period (one capture and one launch strobe with SCK held low) and then goes high.
- R11: While idle, capture and launch strobes have no effect: SCK stays low and chip select stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_cap | input | 1 | Capture strobe from the clock generator (SCK rising) |
| sck_lnc | input | 1 | Launch strobe from the clock generator (SCK falling) |
| start_req | input | 1 | Start a transaction with the command fields below |
| cmd_fmt | input | 3 | Lane format code |
| cmd_addr_bytes | input | 3 | Address byte count (0, 3 or 4) |
| cmd_dummy | input | DUMMY_W | Dummy SCK periods |
| cmd_tx_len | input | LEN_W | Write data bytes, excluding opcode and address |
| cmd_rx_len | input | LEN_W | Read data bytes |
| busy | output | 1 | A transaction is in progress |
| start_refused | output | 1 | Pulse: the last start request came while busy |
| tx_data | input | 8 | Outgoing byte stream: opcode, address, write data |
| tx_valid | input | 1 | Outgoing byte is valid |
| tx_ready | output | 1 | Engine takes the outgoing byte |
| rx_data | output | 8 | Captured read byte |
| rx_valid | output | 1 | Captured byte is valid |
| rx_ready | input | 1 | Consumer takes the captured byte |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| dq_o | output | 4 | Lane output values |
| dq_oe | output | 4 | Lane output enables |
| dq_i | input | 4 | Lane input values |
| tx_done | output | 1 | Sticky: all outgoing bytes sent |
| rx_done | output | 1 | Sticky: all read bytes captured |

## Verification
The hardest situations to reach are the phase boundaries where the lane width changes. Examples are a one-lane opcode followed by a two-lane or four-lane address, and the switch from driven write lanes to released read lanes. A refused start that lands in the middle of a live transaction is also hard to reach. The stimulus walks every format code with both 3-byte and 4-byte addresses, and adds random mixes of zero and non-zero phase counts so that each skip path is taken. A second start is pulsed just after the first has been accepted. At every SCK period the bench predicts the lane enables and lane values from the format table, drives read bits on the lanes it expects to be sampled, and compares the rebuilt read bytes with the stream output.

// File: rtl/sflash_pkg.sv
// Shared types and lane-width helpers for the serial flash sequencer.
// Assumes lane widths are encoded as log2(lanes): 0 -> 1, 1 -> 2, 2 -> 4.
package sflash_pkg;

    localparam int DQ_W = 4;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_OPC  = 3'd1,
        PH_ADR  = 3'd2,
        PH_DMY  = 3'd3,
        PH_TXD  = 3'd4,
        PH_RXD  = 3'd5,
        PH_TAIL = 3'd6
    } phase_e;

    // log2 of the lane count used by a phase under a format code
    function automatic logic [1:0] lane_log2(input logic [2:0] fmt, input phase_e ph);
        logic [1:0] op_w, ad_w, dt_w;
        case (fmt)
            3'd2:    begin op_w = 2'd0; ad_w = 2'd0; dt_w = 2'd1; end
            3'd3:    begin op_w = 2'd0; ad_w = 2'd0; dt_w = 2'd2; end
            3'd4:    begin op_w = 2'd0; ad_w = 2'd1; dt_w = 2'd1; end
            3'd5:    begin op_w = 2'd0; ad_w = 2'd2; dt_w = 2'd2; end
            3'd6:    begin op_w = 2'd1; ad_w = 2'd1; dt_w = 2'd1; end
            3'd7:    begin op_w = 2'd2; ad_w = 2'd2; dt_w = 2'd2; end
            default: begin op_w = 2'd0; ad_w = 2'd0; dt_w = 2'd0; end
        endcase
        case (ph)
            PH_OPC:  return op_w;
            PH_ADR:  return ad_w;
            default: return dt_w;
        endcase
    endfunction

    // lane enable mask for a lane width
    function automatic logic [DQ_W-1:0] lane_mask(input logic [1:0] lw);
        case (lw)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // SCK periods per byte, minus one
    function automatic logic [2:0] beats_m1(input logic [1:0] lw);
        case (lw)
            2'd0:    return 3'd7;
            2'd1:    return 3'd3;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/sflash_lane_map.sv
// Decodes the current phase and format code into the active lane width,
// the lane output enables and the phase direction.
// Assumes format code 1 behaves like code 0. Idle releases every lane.
module sflash_lane_map
    import sflash_pkg::*;
(
    input  logic [2:0]      fmt,
    input  phase_e          phase,
    output logic [1:0]      lsel,
    output logic [DQ_W-1:0] oe,
    output logic            is_tx,
    output logic            is_rx
);

    // width and drive pattern per phase
    always_comb begin
        lsel  = lane_log2(fmt, phase);
        is_tx = (phase == PH_OPC) || (phase == PH_ADR) || (phase == PH_TXD);
        is_rx = (phase == PH_RXD);
        if (phase == PH_IDLE) begin
            oe = '0;
        end else if (is_tx) begin
            oe = lane_mask(lsel);
        end else begin
            oe = (lsel == 2'd0) ? 4'b0001 : 4'b0000;
        end
    end

endmodule

// File: rtl/sflash_rx_pack.sv
// Packs sampled input lanes into bytes, MSB first, and holds each finished
// byte on a valid/ready output until it is taken.
// Assumes the controller only samples when the output slot can absorb a byte.
module sflash_rx_pack
    import sflash_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic            byte_last,
    input  logic [1:0]      lsel,
    input  logic [DQ_W-1:0] dq_i,
    input  logic            rx_ready,
    output logic [7:0]      rx_data,
    output logic            rx_valid
);

    logic [7:0] acc_q;
    logic [7:0] acc_nx;

    // merge this beat's lanes into the partial byte
    always_comb begin
        case (lsel)
            2'd0:    acc_nx = {acc_q[6:0], dq_i[1]};
            2'd1:    acc_nx = {acc_q[5:0], dq_i[1:0]};
            default: acc_nx = {acc_q[3:0], dq_i[3:0]};
        endcase
    end

    // accumulate samples and publish finished bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            if (cap_en) begin
                acc_q <= acc_nx;
            end
            if (cap_en && byte_last) begin
                rx_data  <= acc_nx;
                rx_valid <= 1'b1;
            end else if (rx_ready) begin
                rx_valid <= 1'b0;
            end
        end
    end

    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

endmodule

// File: rtl/sflash_seq.sv
// Transaction sequencer: runs opcode, address, dummy, write and read phases
// under one chip select, pacing each SCK period by external strobes.
// Assumes the capture and launch strobes alternate and never share a cycle.
module sflash_seq
    import sflash_pkg::*;
#(
    parameter int LEN_W   = 16,
    parameter int DUMMY_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_cap,
    input  logic               sck_lnc,
    input  logic               start_req,
    input  logic [2:0]         cmd_fmt,
    input  logic [2:0]         cmd_addr_bytes,
    input  logic [DUMMY_W-1:0] cmd_dummy,
    input  logic [LEN_W-1:0]   cmd_tx_len,
    input  logic [LEN_W-1:0]   cmd_rx_len,
    output logic               busy,
    output logic               start_refused,
    input  logic [7:0]         tx_data,
    input  logic               tx_valid,
    output logic               tx_ready,
    output logic [7:0]         rx_data,
    output logic               rx_valid,
    input  logic               rx_ready,
    output logic               sck,
    output logic               cs_n,
    output logic [DQ_W-1:0]    dq_o,
    output logic [DQ_W-1:0]    dq_oe,
    input  logic [DQ_W-1:0]    dq_i,
    output logic               tx_done,
    output logic               rx_done
);

    localparam int REM_W = LEN_W + 1;

    phase_e             phase;
    phase_e             nxt_ph;
    logic [2:0]         fmt_q;
    logic [2:0]         nadr_q;
    logic [DUMMY_W-1:0] ndmy_q;
    logic [DUMMY_W-1:0] dmy_left;
    logic [LEN_W-1:0]   ntx_q;
    logic [LEN_W-1:0]   nrx_q;
    logic [LEN_W-1:0]   bytes_left;
    logic [LEN_W-1:0]   nxt_bytes;
    logic [REM_W-1:0]   tx_rem;
    logic [2:0]         beat_left;
    logic [2:0]         nxt_bl;
    logic [7:0]         sh;
    logic               loaded;
    logic               sck_q;
    logic               cs_n_q;
    logic               tail_half;
    logic               txd_q;
    logic               rxd_q;
    logic               refused_q;

    logic [1:0]         lsel;
    logic [DQ_W-1:0]    oe_w;
    logic               is_tx;
    logic               is_rx;
    logic               is_dmy;
    logic               active;
    logic               cap_ok;
    logic               cap_fire;
    logic               lnc_fire;
    logic               byte_end;
    logic [DQ_W-1:0]    lanes_out;

    sflash_lane_map u_map (
        .fmt   (fmt_q),
        .phase (phase),
        .lsel  (lsel),
        .oe    (oe_w),
        .is_tx (is_tx),
        .is_rx (is_rx)
    );

    // strobe qualification for the current SCK period
    always_comb begin
        is_dmy   = (phase == PH_DMY);
        active   = (phase != PH_IDLE) && (phase != PH_TAIL);
        byte_end = (beat_left == 3'd0);
        if (is_tx)      cap_ok = loaded;
        else if (is_rx) cap_ok = !rx_valid || rx_ready;
        else            cap_ok = is_dmy;
        cap_fire = active && !sck_q && sck_cap && cap_ok;
        lnc_fire = active && sck_q && sck_lnc;
    end

    // phase that follows the current one, skipping empty phases
    always_comb begin
        case (phase)
            PH_OPC:  nxt_ph = (nadr_q != 3'd0) ? PH_ADR :
                              (ndmy_q != '0) ? PH_DMY :
                              (ntx_q != '0) ? PH_TXD :
                              (nrx_q != '0) ? PH_RXD : PH_TAIL;
            PH_ADR:  nxt_ph = (ndmy_q != '0) ? PH_DMY :
                              (ntx_q != '0) ? PH_TXD :
                              (nrx_q != '0) ? PH_RXD : PH_TAIL;
            PH_DMY:  nxt_ph = (ntx_q != '0) ? PH_TXD :
                              (nrx_q != '0) ? PH_RXD : PH_TAIL;
            PH_TXD:  nxt_ph = (nrx_q != '0) ? PH_RXD : PH_TAIL;
            default: nxt_ph = PH_TAIL;
        endcase
        case (nxt_ph)
            PH_ADR:  nxt_bytes = LEN_W'(nadr_q);
            PH_TXD:  nxt_bytes = ntx_q;
            PH_RXD:  nxt_bytes = nrx_q;
            default: nxt_bytes = LEN_W'(1);
        endcase
        nxt_bl = beats_m1(lane_log2(fmt_q, nxt_ph));
    end

    // lane values for the bits at the top of the shift register
    always_comb begin
        case (lsel)
            2'd0:    lanes_out = {3'b000, sh[7]};
            2'd1:    lanes_out = {2'b00, sh[7:6]};
            default: lanes_out = sh[7:4];
        endcase
    end

    // transaction state, shift register and status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            fmt_q      <= '0;
            nadr_q     <= '0;
            ndmy_q     <= '0;
            dmy_left   <= '0;
            ntx_q      <= '0;
            nrx_q      <= '0;
            bytes_left <= '0;
            tx_rem     <= '0;
            beat_left  <= '0;
            sh         <= '0;
            loaded     <= 1'b0;
            sck_q      <= 1'b0;
            cs_n_q     <= 1'b1;
            tail_half  <= 1'b0;
            txd_q      <= 1'b0;
            rxd_q      <= 1'b0;
            refused_q  <= 1'b0;
        end else begin
            refused_q <= start_req && (phase != PH_IDLE);
            if (phase == PH_IDLE) begin
                if (start_req) begin
                    phase      <= PH_OPC;
                    fmt_q      <= cmd_fmt;
                    nadr_q     <= cmd_addr_bytes;
                    ndmy_q     <= cmd_dummy;
                    dmy_left   <= cmd_dummy;
                    ntx_q      <= cmd_tx_len;
                    nrx_q      <= cmd_rx_len;
                    bytes_left <= LEN_W'(1);
                    tx_rem     <= REM_W'(cmd_addr_bytes) + REM_W'(cmd_tx_len) + REM_W'(1);
                    beat_left  <= beats_m1(lane_log2(cmd_fmt, PH_OPC));
                    loaded     <= 1'b0;
                    sck_q      <= 1'b0;
                    cs_n_q     <= 1'b0;
                    tail_half  <= 1'b0;
                    txd_q      <= 1'b0;
                    rxd_q      <= 1'b0;
                end
            end else begin
                if (tx_ready && tx_valid) begin
                    sh     <= tx_data;
                    loaded <= 1'b1;
                end
                if (cap_fire) begin
                    sck_q <= 1'b1;
                    if (is_rx && byte_end && bytes_left == LEN_W'(1)) begin
                        rxd_q <= 1'b1;
                    end
                end
                if (lnc_fire) begin
                    sck_q <= 1'b0;
                    if (is_dmy) begin
                        if (dmy_left <= DUMMY_W'(1)) begin
                            phase      <= nxt_ph;
                            bytes_left <= nxt_bytes;
                            beat_left  <= nxt_bl;
                            loaded     <= 1'b0;
                        end else begin
                            dmy_left <= dmy_left - DUMMY_W'(1);
                        end
                    end else if (!byte_end) begin
                        beat_left <= beat_left - 3'd1;
                        case (lsel)
                            2'd0:    sh <= {sh[6:0], 1'b0};
                            2'd1:    sh <= {sh[5:0], 2'b00};
                            default: sh <= {sh[3:0], 4'b0000};
                        endcase
                    end else begin
                        if (is_tx) begin
                            loaded <= 1'b0;
                            tx_rem <= tx_rem - REM_W'(1);
                            if (tx_rem == REM_W'(1)) txd_q <= 1'b1;
                        end
                        if (bytes_left > LEN_W'(1)) begin
                            bytes_left <= bytes_left - LEN_W'(1);
                            beat_left  <= beats_m1(lsel);
                        end else begin
                            phase      <= nxt_ph;
                            bytes_left <= nxt_bytes;
                            beat_left  <= nxt_bl;
                            dmy_left   <= ndmy_q;
                        end
                    end
                end
                if (phase == PH_TAIL) begin
                    if (sck_cap) tail_half <= 1'b1;
                    if (sck_lnc && tail_half) begin
                        cs_n_q <= 1'b1;
                        phase  <= PH_IDLE;
                    end
                end
            end
        end
    end

    sflash_rx_pack u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (cap_fire && is_rx),
        .byte_last (byte_end),
        .lsel      (lsel),
        .dq_i      (dq_i),
        .rx_ready  (rx_ready),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );

    assign busy          = (phase != PH_IDLE);
    assign start_refused = refused_q;
    assign tx_ready      = is_tx && !loaded;
    assign sck           = sck_q;
    assign cs_n          = cs_n_q;
    assign dq_o          = is_tx ? lanes_out : '0;
    assign dq_oe         = oe_w;
    assign tx_done       = txd_q;
    assign rx_done       = rxd_q;

    assert_cs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    assert_sck_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    assert_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_req && busy |=> start_refused);

    assert_done_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_done && !rx_done);

    assert_rx_after_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> tx_done);

    assert_lanes_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> dq_oe == 4'b0000);

endmodule

// File: tb/sim_sflash_seq.sv
module sim_sflash_seq;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 16;
    localparam int DUMMY_W    = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               sck_cap = 1'b0;
    logic               sck_lnc = 1'b0;
    logic               start_req = 1'b0;
    logic [2:0]         cmd_fmt = '0;
    logic [2:0]         cmd_addr_bytes = '0;
    logic [DUMMY_W-1:0] cmd_dummy = '0;
    logic [LEN_W-1:0]   cmd_tx_len = '0;
    logic [LEN_W-1:0]   cmd_rx_len = '0;
    logic               busy, start_refused;
    logic [7:0]         tx_data;
    logic               tx_valid = 1'b1;
    logic               tx_ready;
    logic [7:0]         rx_data;
    logic               rx_valid;
    logic               rx_ready = 1'b1;
    logic               sck, cs_n;
    logic [3:0]         dq_o, dq_oe;
    logic [3:0]         dq_i = '0;
    logic               tx_done, rx_done;

    int checks = 0;
    int fails  = 0;
    int tx_idx = 0;
    int rx_cnt = 0;
    logic [7:0] tx_stream [64];
    logic [7:0] rx_exp    [64];
    logic [7:0] rx_got    [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    sflash_seq #(.LEN_W(LEN_W), .DUMMY_W(DUMMY_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sck_cap(sck_cap), .sck_lnc(sck_lnc),
        .start_req(start_req), .cmd_fmt(cmd_fmt), .cmd_addr_bytes(cmd_addr_bytes),
        .cmd_dummy(cmd_dummy), .cmd_tx_len(cmd_tx_len), .cmd_rx_len(cmd_rx_len),
        .busy(busy), .start_refused(start_refused),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .sck(sck), .cs_n(cs_n), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i),
        .tx_done(tx_done), .rx_done(rx_done)
    );

    assign tx_data = tx_stream[tx_idx[5:0]];

    // stream-side model: feeds outgoing bytes and records incoming ones
    always @(posedge clk) begin
        if (start_req && !busy) begin
            tx_idx <= 0;
            rx_cnt <= 0;
        end else begin
            if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
            if (rx_valid && rx_ready) begin
                rx_got[rx_cnt[5:0]] <= rx_data;
                rx_cnt <= rx_cnt + 1;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int w_op(input int f);
        return (f == 7) ? 4 : ((f == 6) ? 2 : 1);
    endfunction
    function automatic int w_ad(input int f);
        return (f == 5 || f == 7) ? 4 : ((f == 4 || f == 6) ? 2 : 1);
    endfunction
    function automatic int w_dt(input int f);
        return (f == 3 || f == 5 || f == 7) ? 4 : ((f == 2 || f == 4 || f == 6) ? 2 : 1);
    endfunction
    function automatic logic [3:0] mask4(input int w);
        return (w == 1) ? 4'b0001 : ((w == 2) ? 4'b0011 : 4'b1111);
    endfunction

    task automatic pulse_cap();
        @(negedge clk) sck_cap = 1'b1;
        @(negedge clk) sck_cap = 1'b0;
    endtask
    task automatic pulse_lnc();
        @(negedge clk) sck_lnc = 1'b1;
        @(negedge clk) sck_lnc = 1'b0;
    endtask

    // one SCK period: kind 0 = transmit, 1 = dummy, 2 = receive
    task automatic beat(input int kind, input int w, input logic [7:0] b, input int j, input string req);
        logic [7:0] bits;
        @(negedge clk);
        @(negedge clk);
        bits = 8'((b >> (8 - w * (j + 1))) & {4'b0000, mask4(w)});
        if (kind == 0) begin
            chk({req, " lane enables"}, 32'(dq_oe), 32'(mask4(w)));
            chk({req, " lane values"}, 32'(dq_o & mask4(w)), 32'(bits));
        end else begin
            chk("R5 released lanes", 32'(dq_oe), (w == 1) ? 32'd1 : 32'd0);
            chk("R5 driven lanes low", 32'(dq_o & dq_oe), 32'd0);
        end
        if (kind == 2) begin
            dq_i = (w == 1) ? {2'b00, bits[0], 1'b0} : bits[3:0];
        end
        pulse_cap();
        chk("R10 sck high after capture", 32'(sck), 32'd1);
        chk("R10 cs low in transaction", 32'(cs_n), 32'd0);
        pulse_lnc();
        chk("R10 sck low after launch", 32'(sck), 32'd0);
    endtask

    task automatic run_txn(input int f, input int na, input int nd, input int ntx, input int nrx, input bit refuse);
        for (int i = 0; i < 1 + na + ntx; i++) tx_stream[i] = 8'($urandom);
        for (int i = 0; i < nrx; i++) rx_exp[i] = 8'($urandom);
        @(negedge clk);
        start_req      = 1'b1;
        cmd_fmt        = 3'(f);
        cmd_addr_bytes = 3'(na);
        cmd_dummy      = DUMMY_W'(nd);
        cmd_tx_len     = LEN_W'(ntx);
        cmd_rx_len     = LEN_W'(nrx);
        @(negedge clk);
        start_req = 1'b0;
        chk("R9 busy after start", 32'(busy), 32'd1);
        chk("R8 tx_done cleared", 32'(tx_done), 32'd0);
        chk("R8 rx_done cleared", 32'(rx_done), 32'd0);
        chk("R10 cs low on start", 32'(cs_n), 32'd0);
        if (refuse) begin
            start_req      = 1'b1;
            cmd_fmt        = 3'(f) ^ 3'd7;
            cmd_addr_bytes = 3'd0;
            cmd_rx_len     = '0;
            @(negedge clk);
            start_req = 1'b0;
            chk("R9 refusal pulse", 32'(start_refused), 32'd1);
        end
        for (int j = 0; j < 8 / w_op(f); j++) beat(0, w_op(f), tx_stream[0], j, "R2 opcode");
        for (int a = 0; a < na; a++)
            for (int j = 0; j < 8 / w_ad(f); j++) beat(0, w_ad(f), tx_stream[1 + a], j, "R3 address");
        for (int d = 0; d < nd; d++) beat(1, w_dt(f), 8'h00, 0, "R5");
        for (int t = 0; t < ntx; t++)
            for (int j = 0; j < 8 / w_dt(f); j++) beat(0, w_dt(f), tx_stream[1 + na + t], j, "R4 write data");
        for (int r = 0; r < nrx; r++)
            for (int j = 0; j < 8 / w_dt(f); j++) beat(2, w_dt(f), rx_exp[r], j, "R4 read data");
        @(negedge clk);
        @(negedge clk);
        chk("R10 cs still low before tail", 32'(cs_n), 32'd0);
        pulse_cap();
        chk("R10 sck low during tail", 32'(sck), 32'd0);
        chk("R10 cs low during tail", 32'(cs_n), 32'd0);
        pulse_lnc();
        chk("R10 cs high after tail", 32'(cs_n), 32'd1);
        chk("R10 idle after tail", 32'(busy), 32'd0);
        chk("R8 tx_done at end", 32'(tx_done), 32'd1);
        chk("R7 rx_done at end", 32'(rx_done), (nrx > 0) ? 32'd1 : 32'd0);
        chk("R7 read byte count", 32'(rx_cnt), 32'(nrx));
        chk("R6 bytes taken from stream", 32'(tx_idx), 32'(1 + na + ntx));
        for (int r = 0; r < nrx; r++) chk("R7 read byte value", 32'(rx_got[r]), 32'(rx_exp[r]));
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20515));
        repeat (4) @(negedge clk);
        // R1: state during and after reset
        chk("R1 cs high in reset", 32'(cs_n), 32'd1);
        chk("R1 sck low in reset", 32'(sck), 32'd0);
        chk("R1 lanes released in reset", 32'(dq_oe), 32'd0);
        chk("R1 not busy in reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx_ready low", 32'(tx_ready), 32'd0);
        chk("R1 rx_valid low", 32'(rx_valid), 32'd0);
        chk("R1 done flags low", 32'({tx_done, rx_done}), 32'd0);
        // R11: strobes while idle
        pulse_cap();
        chk("R11 sck low while idle", 32'(sck), 32'd0);
        pulse_lnc();
        chk("R11 cs high while idle", 32'(cs_n), 32'd1);
        chk("R11 still idle", 32'(busy), 32'd0);
        // directed: every format code
        for (int f = 0; f < 8; f++) run_txn(f, (f % 2 == 1) ? 4 : 3, f % 4, 2, 2, 1'b0);
        run_txn(0, 0, 0, 0, 0, 1'b0);
        run_txn(7, 4, 0, 0, 3, 1'b1);
        run_txn(2, 0, 3, 0, 1, 1'b0);
        run_txn(5, 3, 0, 3, 0, 1'b1);
        // constrained random mixes
        for (int k = 0; k < 16; k++) begin
            int f, na, nd, ntx, nrx;
            bit rf;
            f   = int'($urandom % 8);
            na  = (($urandom % 3) == 0) ? 0 : ((($urandom % 2) == 0) ? 3 : 4);
            nd  = int'($urandom % 6);
            ntx = int'($urandom % 5);
            nrx = int'($urandom % 5);
            rf  = 1'($urandom % 2);
            run_txn(f, na, nd, ntx, nrx, rf);
        end
        finish_up();
    end

endmodule